// File: doc/BRIEF.md
# Descriptor-Chained Framebuffer Fetcher

This block pulls display data out of memory for a panel controller. Each channel walks a linked list of four-word descriptors held in memory. A descriptor gives the address of the next descriptor, a source address, an identifier word that the block reads and ignores, and a command word. The command word carries a transfer length in 32-bit words and three flag bits. The channel reads the source region in bursts of a selectable size and queues the words in a local buffer. A downstream consumer pops the words from that buffer. Each word carries a tag that says whether it is palette data or frame data.

A typical chain has a palette descriptor linked to a framebuffer descriptor, which links back to the palette descriptor. Without a palette, one framebuffer descriptor links to itself. A second channel, which is only active in dual-panel mode, runs its own self-linked chain for the lower half of the screen. The next descriptor is requested in the cycle after the last word of a transfer arrives, so there is no idle gap between frames. The block pulses frame-start and frame-end events when the descriptor flags ask for them, and it keeps a sticky underrun flag for each channel.

Top module: `fbdma_fetch`

## Requirements
- R1: While reset is high and in the first cycle after it, every channel shows no memory request, no available word, a cleared underrun flag, and no frame event.
- R2: A descriptor is fetched as one memory request of length 4 at the descriptor address. The first request after `run` rises uses that channel's `desc_base`. Memory returns the next pointer, source, identifier and command in that order. Each channel has at most one request outstanding, and `mem_req` is a one-cycle pulse.
- R3: `burst_sel` codes map to burst lengths as 0→4, 1→8, 2→16, 3→32, 4→64; every other code gives 16. The data requests of a descriptor use that length at consecutive addresses starting at the source: source, source+4·B, source+8·B, and so on.
- R4: The transfer length is command bits [LEN_W-1:0], in words, rounded up to a whole number of bursts. A length of zero causes no data request, and the next descriptor is fetched straight away.
- R5: When `run` is high, the request for the next descriptor goes out one cycle after the last word of the current transfer is returned. The address of that request is the next pointer read from the current descriptor.
- R6: Every word fetched for a descriptor whose command bit 28 is set is presented with `out_pal`=1. Words from any other descriptor are presented with `out_pal`=0.
- R7: `frame_start` pulses one cycle after the command word of a descriptor with bit 30 set arrives. `frame_end` pulses one cycle after the last data word of a descriptor with bit 31 set arrives. A zero-length descriptor raises neither event.
- R8: The output is show-ahead. When `out_avail` is high, `out_data` and `out_pal` hold the oldest fetched word, and `out_rd` removes it. Words leave in memory order.
- R9: A data burst is requested only when the buffer has room for the whole burst, so the number of words held never exceeds FIFO_DEPTH.
- R10: `out_rd` asserted while `out_avail` is low sets that channel's `underrun` flag. The flag stays set until reset and does not affect any other channel.
- R11: Channel 0 follows `run`. Channel 1 follows `run` only while `dual` is high, and it fetches from its own descriptor chain. With `dual` low, channel 1 issues no requests.
- R12: When `run` goes low, the channel finishes its current descriptor's transfer and then issues no further requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start, or keep fetching |
| dual | input | 1 | Dual-panel mode; enables channel 1 |
| burst_sel | input | 3 | Burst length code |
| desc_base | input | NUM_CH×32 | First descriptor address for each channel |
| mem_req | output | NUM_CH | Read request pulse |
| mem_addr | output | NUM_CH×32 | Byte address of the request |
| mem_len | output | NUM_CH×7 | Words requested |
| mem_rvalid | input | NUM_CH | Read word valid |
| mem_rdata | input | NUM_CH×32 | Read word |
| out_avail | output | NUM_CH | Buffered word available |
| out_data | output | NUM_CH×32 | Oldest buffered word |
| out_pal | output | NUM_CH | Palette tag of that word |
| out_rd | input | NUM_CH | Pop request from the consumer |
| underrun | output | NUM_CH | Sticky underrun flag |
| frame_start | output | NUM_CH | Frame-start event pulse |
| frame_end | output | NUM_CH | Frame-end event pulse |

## Verification
The assertions assume a memory that returns exactly the number of words requested, in order, and only after the request, with arbitrary idle cycles between them. They also assume that `burst_sel`, `desc_base` and the descriptors stay unchanged while a channel is running. The bench memory model follows a chain that it builds itself. It serves only the words it has been asked for, and each word goes out with a random chance so that gaps occur. Burst codes, bases and descriptor contents are changed only while reset is held. Lengths are drawn at random within each descriptor's range, and the consumer pops at random rates.

// File: rtl/fbdma_pkg.sv
package fbdma_pkg;

    localparam int DESC_WORDS  = 4;
    localparam int BLEN_W      = 7;
    localparam int PAL_BIT     = 28;
    localparam int SOF_BIT     = 30;
    localparam int EOF_BIT     = 31;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DESC,
        ST_ISSUE,
        ST_DATA
    } fetch_state_e;

    typedef struct packed {
        logic        pal;
        logic [31:0] word;
    } fifo_ent_t;

    typedef struct packed {
        logic pal;
        logic eof;
    } xfer_flags_t;

    // burst length in words for a selection code
    function automatic logic [BLEN_W-1:0] burst_words(input logic [2:0] code);
        case (code)
            3'd0:    return 7'd4;
            3'd1:    return 7'd8;
            3'd3:    return 7'd32;
            3'd4:    return 7'd64;
            default: return 7'd16;
        endcase
    endfunction

    // round a word count up to a multiple of a power-of-two burst
    function automatic logic [31:0] round_to_burst(input logic [31:0] n,
                                                   input logic [BLEN_W-1:0] b);
        logic [31:0] m;
        m = {25'd0, b} - 32'd1;
        return (n + m) & ~m;
    endfunction

endpackage

// File: rtl/fbdma_fifo.sv
module fbdma_fifo
    import fbdma_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  fifo_ent_t                  push_ent,
    input  logic                       pop,
    output fifo_ent_t                  head,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     space
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    fifo_ent_t         store [DEPTH];
    logic [PW-1:0]     wp, rp;
    logic [CW-1:0]     cnt;

    always_ff @(posedge clk) begin
        if (push) store[wp] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head  = store[rp];
    assign empty = (cnt == '0);
    assign space = CW'(DEPTH) - cnt;

endmodule

// File: rtl/fbdma_engine.sv
module fbdma_engine
    import fbdma_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int FIFO_DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         run,
    input  logic [31:0]                  desc_base,
    input  logic [2:0]                   burst_code,
    output logic                         mem_req,
    output logic [31:0]                  mem_addr,
    output logic [BLEN_W-1:0]            mem_len,
    input  logic                         mem_rvalid,
    input  logic [31:0]                  mem_rdata,
    input  logic [$clog2(FIFO_DEPTH):0]  fifo_space,
    output logic                         push,
    output fifo_ent_t                    push_ent,
    output logic                         frame_start,
    output logic                         frame_end
);
    localparam logic [31:0] LEN_MASK = (32'd1 << LEN_W) - 32'd1;

    fetch_state_e      st;
    logic [1:0]        dbeat;
    logic [BLEN_W-1:0] bbeat, blen_q;
    logic [31:0]       nxt_q, cur_q, left_q;
    xfer_flags_t       fl_q;
    logic [31:0]       tot;

    assign tot      = round_to_burst(mem_rdata & LEN_MASK, burst_words(burst_code));
    assign push     = (st == ST_DATA) && mem_rvalid;
    assign push_ent = '{pal: fl_q.pal, word: mem_rdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            dbeat       <= '0;
            bbeat       <= '0;
            blen_q      <= '0;
            nxt_q       <= '0;
            cur_q       <= '0;
            left_q      <= '0;
            fl_q        <= '0;
            mem_req     <= 1'b0;
            mem_addr    <= '0;
            mem_len     <= '0;
            frame_start <= 1'b0;
            frame_end   <= 1'b0;
        end else begin
            mem_req     <= 1'b0;
            frame_start <= 1'b0;
            frame_end   <= 1'b0;
            case (st)
                ST_IDLE: if (run) begin
                    mem_req  <= 1'b1;
                    mem_addr <= desc_base;
                    mem_len  <= BLEN_W'(DESC_WORDS);
                    dbeat    <= '0;
                    st       <= ST_DESC;
                end
                ST_DESC: if (mem_rvalid) begin
                    dbeat <= dbeat + 1'b1;
                    case (dbeat)
                        2'd0: nxt_q <= mem_rdata;
                        2'd1: cur_q <= mem_rdata;
                        2'd2: ;
                        default: begin
                            blen_q   <= burst_words(burst_code);
                            left_q   <= tot;
                            fl_q.pal <= mem_rdata[PAL_BIT];
                            fl_q.eof <= mem_rdata[EOF_BIT];
                            if (tot == '0) begin
                                if (run) begin
                                    mem_req  <= 1'b1;
                                    mem_addr <= nxt_q;
                                    mem_len  <= BLEN_W'(DESC_WORDS);
                                    dbeat    <= '0;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else begin
                                frame_start <= mem_rdata[SOF_BIT];
                                st          <= ST_ISSUE;
                            end
                        end
                    endcase
                end
                ST_ISSUE: if (int'(fifo_space) >= int'(blen_q)) begin
                    mem_req  <= 1'b1;
                    mem_addr <= cur_q;
                    mem_len  <= blen_q;
                    cur_q    <= cur_q + {23'd0, blen_q, 2'b00};
                    left_q   <= left_q - {25'd0, blen_q};
                    bbeat    <= '0;
                    st       <= ST_DATA;
                end
                ST_DATA: if (mem_rvalid) begin
                    bbeat <= bbeat + 1'b1;
                    if (bbeat == blen_q - 7'd1) begin
                        if (left_q == '0) begin
                            frame_end <= fl_q.eof;
                            if (run) begin
                                mem_req  <= 1'b1;
                                mem_addr <= nxt_q;
                                mem_len  <= BLEN_W'(DESC_WORDS);
                                dbeat    <= '0;
                                st       <= ST_DESC;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else begin
                            st <= ST_ISSUE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fbdma_chan.sv
module fbdma_chan
    import fbdma_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int FIFO_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [31:0]       desc_base,
    input  logic [2:0]        burst_code,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    output logic [BLEN_W-1:0] mem_len,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              out_avail,
    output logic [31:0]       out_data,
    output logic              out_pal,
    input  logic              out_rd,
    output logic              underrun,
    output logic              frame_start,
    output logic              frame_end
);
    logic                         push, empty, pop;
    fifo_ent_t                    push_ent, head;
    logic [$clog2(FIFO_DEPTH):0]  space;

    fbdma_engine #(.LEN_W(LEN_W), .FIFO_DEPTH(FIFO_DEPTH)) u_eng (
        .clk(clk), .rst(rst), .run(run), .desc_base(desc_base),
        .burst_code(burst_code), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .fifo_space(space), .push(push), .push_ent(push_ent),
        .frame_start(frame_start), .frame_end(frame_end)
    );

    fbdma_fifo #(.DEPTH(FIFO_DEPTH)) u_buf (
        .clk(clk), .rst(rst), .push(push), .push_ent(push_ent),
        .pop(pop), .head(head), .empty(empty), .space(space)
    );

    assign pop       = out_rd && !empty;
    assign out_avail = !empty;
    assign out_data  = head.word;
    assign out_pal   = head.pal;

    always_ff @(posedge clk) begin
        if (rst) underrun <= 1'b0;
        else if (out_rd && empty) underrun <= 1'b1;
    end

endmodule

// File: rtl/fbdma_fetch.sv
module fbdma_fetch
    import fbdma_pkg::*;
#(
    parameter int NUM_CH     = 2,
    parameter int LEN_W      = 16,
    parameter int FIFO_DEPTH = 64
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           run,
    input  logic                           dual,
    input  logic [2:0]                     burst_sel,
    input  logic [NUM_CH-1:0][31:0]        desc_base,
    output logic [NUM_CH-1:0]              mem_req,
    output logic [NUM_CH-1:0][31:0]        mem_addr,
    output logic [NUM_CH-1:0][BLEN_W-1:0]  mem_len,
    input  logic [NUM_CH-1:0]              mem_rvalid,
    input  logic [NUM_CH-1:0][31:0]        mem_rdata,
    output logic [NUM_CH-1:0]              out_avail,
    output logic [NUM_CH-1:0][31:0]        out_data,
    output logic [NUM_CH-1:0]              out_pal,
    input  logic [NUM_CH-1:0]              out_rd,
    output logic [NUM_CH-1:0]              underrun,
    output logic [NUM_CH-1:0]              frame_start,
    output logic [NUM_CH-1:0]              frame_end
);
    logic [NUM_CH-1:0] ch_run;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        if (c == 0) begin : g_main
            assign ch_run[c] = run;
        end else begin : g_lower
            assign ch_run[c] = run && dual;
        end

        fbdma_chan #(.LEN_W(LEN_W), .FIFO_DEPTH(FIFO_DEPTH)) u_chan (
            .clk(clk), .rst(rst), .run(ch_run[c]), .desc_base(desc_base[c]),
            .burst_code(burst_sel), .mem_req(mem_req[c]), .mem_addr(mem_addr[c]),
            .mem_len(mem_len[c]), .mem_rvalid(mem_rvalid[c]), .mem_rdata(mem_rdata[c]),
            .out_avail(out_avail[c]), .out_data(out_data[c]), .out_pal(out_pal[c]),
            .out_rd(out_rd[c]), .underrun(underrun[c]),
            .frame_start(frame_start[c]), .frame_end(frame_end[c])
        );
    end

endmodule

// File: rtl/fbdma_fetch_chk.sv
module fbdma_fetch_chk
    import fbdma_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           run,
    input logic                           dual,
    input logic [NUM_CH-1:0]              mem_req,
    input logic [NUM_CH-1:0][BLEN_W-1:0]  mem_len,
    input logic [NUM_CH-1:0]              out_avail,
    input logic [NUM_CH-1:0]              out_rd,
    input logic [NUM_CH-1:0]              underrun,
    input logic [NUM_CH-1:0]              frame_start,
    input logic [NUM_CH-1:0]              frame_end
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic go;
        assign go = (c == 0) ? run : (run && dual);

        // R3
        req_len_chk: assert property (@(posedge clk) disable iff (rst)
            mem_req[c] |-> (mem_len[c] == 7'd4 || mem_len[c] == 7'd8 ||
                            mem_len[c] == 7'd16 || mem_len[c] == 7'd32 ||
                            mem_len[c] == 7'd64));

        // R2
        one_req_chk: assert property (@(posedge clk) disable iff (rst)
            mem_req[c] |=> !mem_req[c]);

        // R5
        chain_gap_chk: assert property (@(posedge clk) disable iff (rst)
            (frame_end[c] && $past(go)) |-> (mem_req[c] && mem_len[c] == 7'd4));

        // R7
        event_apart_chk: assert property (@(posedge clk) disable iff (rst)
            frame_start[c] |-> !frame_end[c]);

        // R10
        underrun_set_chk: assert property (@(posedge clk) disable iff (rst)
            (out_rd[c] && !out_avail[c]) |=> underrun[c]);

        // R10
        underrun_hold_chk: assert property (@(posedge clk) disable iff (rst)
            underrun[c] |=> underrun[c]);
    end

endmodule

bind fbdma_fetch fbdma_fetch_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst(rst), .run(run), .dual(dual), .mem_req(mem_req),
    .mem_len(mem_len), .out_avail(out_avail), .out_rd(out_rd),
    .underrun(underrun), .frame_start(frame_start), .frame_end(frame_end)
);

// File: tb/fbdma_fetch_tb.sv
module fbdma_fetch_tb;
    localparam int NCH = 2;
    localparam int FD  = 64;
    localparam int MW  = 4096;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                 rst = 1'b1, run = 1'b0, dual = 1'b0;
    logic [2:0]           burst_sel = 3'd2;
    logic [NCH-1:0][31:0] desc_base = '0;
    logic [NCH-1:0]       mem_req, out_avail, out_pal, underrun, frame_start, frame_end;
    logic [NCH-1:0][31:0] mem_addr, out_data;
    logic [NCH-1:0][6:0]  mem_len;
    logic [NCH-1:0]       mem_rvalid = '0, out_rd = '0;
    logic [NCH-1:0][31:0] mem_rdata = '0;

    fbdma_fetch #(.NUM_CH(NCH), .LEN_W(16), .FIFO_DEPTH(FD)) u_dut (
        .clk(clk), .rst(rst), .run(run), .dual(dual), .burst_sel(burst_sel),
        .desc_base(desc_base), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .out_avail(out_avail), .out_data(out_data), .out_pal(out_pal),
        .out_rd(out_rd), .underrun(underrun), .frame_start(frame_start),
        .frame_end(frame_end)
    );

    logic [31:0] mem [MW];
    int checks = 0, fails = 0;
    int ncyc = 0, bw = 16;
    int phase[NCH], p_addr[NCH], p_len[NCH], p_idx[NCH];
    int d_nxt[NCH], d_src[NCH], d_tot[NCH], d_done[NCH];
    bit d_pal[NCH], d_sof[NCH], d_eof[NCH];
    int exp_ptr[NCH], last_end[NCH], ndesc[NCH], nreq[NCH], rate[NCH];
    bit first[NCH], fs_due[NCH], fe_due[NCH], force_rd[NCH];
    logic [32:0] q0[$], q1[$];

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_burst(input int code);
        case (code)
            0: return 4;
            1: return 8;
            3: return 32;
            4: return 64;
            default: return 16;
        endcase
    endfunction

    function automatic int widx(input int a);
        return (a >>> 2) & (MW - 1);
    endfunction

    function automatic int qsize(input int c);
        return (c == 0) ? q0.size() : q1.size();
    endfunction

    task automatic put_desc(input int a, input int nxt, input int src, input int cmd);
        mem[widx(a)]     = nxt;
        mem[widx(a) + 1] = src;
        mem[widx(a) + 2] = src;
        mem[widx(a) + 3] = cmd;
    endtask

    task automatic consumer_step(input int c);
        logic [32:0] e;
        bit rd;
        if (force_rd[c]) begin
            out_rd[c] = 1'b1;
            return;
        end
        rd = out_avail[c] && (($urandom % 100) < rate[c]);
        out_rd[c] = rd;
        if (rd) begin
            if (qsize(c) == 0) begin
                chk(0, "R8 unexpected word", {32'd0, out_data[c]}, 64'd0);
            end else begin
                e = (c == 0) ? q0.pop_front() : q1.pop_front();
                chk(out_data[c] == e[31:0], "R8 word order", out_data[c], e[31:0]);
                chk(out_pal[c] == e[32], "R6 palette tag", out_pal[c], e[32]);
            end
        end
    endtask

    task automatic model_step(input int c);
        int w, bi, cmd, len;
        if (fs_due[c] || frame_start[c])
            chk(frame_start[c] == fs_due[c], "R7 frame_start", frame_start[c], fs_due[c]);
        if (fe_due[c] || frame_end[c])
            chk(frame_end[c] == fe_due[c], "R7 frame_end", frame_end[c], fe_due[c]);
        fs_due[c] = 0;
        fe_due[c] = 0;
        if (mem_req[c]) begin
            nreq[c]++;
            if (phase[c] == 0) begin
                chk(mem_addr[c] == 32'(exp_ptr[c]) && mem_len[c] == 7'd4,
                    "R2 descriptor request", {mem_addr[c], 25'd0, mem_len[c]},
                    {32'(exp_ptr[c]), 32'd4});
                if (!first[c])
                    chk(ncyc == last_end[c] + 1, "R5 chain gap", 64'(ncyc - last_end[c]), 64'd1);
                first[c] = 0;
                phase[c] = 1;
                p_addr[c] = mem_addr[c];
                p_len[c] = 4;
                p_idx[c] = 0;
            end else if (phase[c] == 2) begin
                chk(mem_addr[c] == 32'(d_src[c] + 4 * d_done[c]) && int'(mem_len[c]) == bw,
                    "R3 burst request", {mem_addr[c], 25'd0, mem_len[c]},
                    {32'(d_src[c] + 4 * d_done[c]), 32'(bw)});
                chk(d_done[c] + bw <= d_tot[c], "R4 rounded length",
                    64'(d_done[c] + bw), 64'(d_tot[c]));
                d_done[c] += bw;
                phase[c] = 3;
                p_addr[c] = mem_addr[c];
                p_len[c] = int'(mem_len[c]);
                p_idx[c] = 0;
            end else begin
                chk(0, "R2 request while busy", 64'(phase[c]), 64'd0);
            end
        end
        mem_rvalid[c] = 1'b0;
        if ((phase[c] == 1 || phase[c] == 3) && (($urandom % 100) < 70)) begin
            w = mem[widx(p_addr[c]) + p_idx[c]];
            mem_rvalid[c] = 1'b1;
            mem_rdata[c] = w;
            if (phase[c] == 3) begin
                if (c == 0) q0.push_back({d_pal[c], w});
                else q1.push_back({d_pal[c], w});
                chk(qsize(c) <= FD, "R9 buffer bound", 64'(qsize(c)), 64'(FD));
            end
            p_idx[c]++;
            if (p_idx[c] == p_len[c]) begin
                if (phase[c] == 1) begin
                    bi = widx(p_addr[c]);
                    d_nxt[c] = mem[bi];
                    d_src[c] = mem[bi + 1];
                    cmd = mem[bi + 3];
                    len = cmd & 32'hFFFF;
                    d_tot[c] = ((len + bw - 1) / bw) * bw;
                    d_done[c] = 0;
                    d_pal[c] = cmd[28];
                    d_sof[c] = cmd[30];
                    d_eof[c] = cmd[31];
                    if (d_tot[c] == 0) begin
                        last_end[c] = ncyc;
                        exp_ptr[c] = d_nxt[c];
                        ndesc[c]++;
                        phase[c] = 0;
                    end else begin
                        fs_due[c] = d_sof[c];
                        phase[c] = 2;
                    end
                end else if (d_done[c] == d_tot[c]) begin
                    fe_due[c] = d_eof[c];
                    last_end[c] = ncyc;
                    exp_ptr[c] = d_nxt[c];
                    ndesc[c]++;
                    phase[c] = 0;
                end else begin
                    phase[c] = 2;
                end
            end
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            ncyc++;
            for (int c = 0; c < NCH; c++) begin
                consumer_step(c);
                model_step(c);
            end
        end
    end

    task automatic clear_model();
        for (int c = 0; c < NCH; c++) begin
            phase[c] = 0; first[c] = 1; ndesc[c] = 0; nreq[c] = 0;
            fs_due[c] = 0; fe_due[c] = 0; force_rd[c] = 0; rate[c] = 60;
        end
        q0.delete();
        q1.delete();
    endtask

    task automatic do_reset(input int code);
        @(negedge clk); #1;
        rst = 1'b1; run = 1'b0; dual = 1'b0;
        clear_model();
        burst_sel = 3'(code);
        bw = exp_burst(code);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        for (int c = 0; c < NCH; c++) begin
            chk(mem_req[c] == 1'b0, "R1 no request", mem_req[c], 0);
            chk(out_avail[c] == 1'b0, "R1 buffer empty", out_avail[c], 0);
            chk(underrun[c] == 1'b0, "R1 underrun clear", underrun[c], 0);
            chk(frame_start[c] == 1'b0 && frame_end[c] == 1'b0, "R1 no events",
                {frame_start[c], frame_end[c]}, 0);
        end
    endtask

    task automatic start_ch(input int c, input int base);
        desc_base[c] = base;
        exp_ptr[c] = base;
    endtask

    task automatic wait_desc(input int c, input int n);
        for (int k = 0; k < 30000 && ndesc[c] < n; k++) @(negedge clk);
        #1;
        chk(ndesc[c] >= n, "R5 chain progress", 64'(ndesc[c]), 64'(n));
    endtask

    task automatic stop_and_drain();
        int r0, r1;
        run = 1'b0;
        repeat (800) @(negedge clk);
        #1;
        chk(phase[0] == 0 && phase[1] == 0, "R12 stopped at boundary",
            64'(phase[0] * 10 + phase[1]), 0);
        r0 = nreq[0];
        r1 = nreq[1];
        repeat (100) @(negedge clk);
        #1;
        chk(nreq[0] == r0 && nreq[1] == r1, "R12 no requests after stop",
            64'(nreq[0] + nreq[1]), 64'(r0 + r1));
        rate[0] = 100;
        rate[1] = 100;
        for (int k = 0; k < 2000 && (q0.size() + q1.size()) > 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        #1;
        chk(out_avail == '0 && q0.size() == 0 && q1.size() == 0, "R8 all words delivered",
            {out_avail, 32'(q0.size() + q1.size())}, 0);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R5 actual=timeout expected=completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int flen;
        void'($urandom(32'd7719));
        for (int i = 0; i < MW; i++) mem[i] = i * 32'h9E3779B1 + 32'h01234567;

        // palette and frame descriptors linked in a loop, burst 8
        do_reset(1);
        flen = 33 + ($urandom % 20);
        put_desc(32'h10, 32'h40, 32'h400, (1 << 28) | 10);
        put_desc(32'h40, 32'h10, 32'h800, (1 << 30) | (1 << 31) | flen);
        start_ch(0, 32'h10);
        run = 1'b1;
        wait_desc(0, 7);
        chk(nreq[1] == 0, "R11 lower channel idle without dual", 64'(nreq[1]), 0);
        stop_and_drain();

        // self-linked frame without a palette, burst 16, fast then slow consumer
        do_reset(2);
        flen = 1 + ($urandom % 60);
        put_desc(32'h80, 32'h80, 32'h1000, (1 << 30) | (1 << 31) | flen);
        start_ch(0, 32'h80);
        rate[0] = 90;
        run = 1'b1;
        wait_desc(0, 2);
        rate[0] = 8;
        wait_desc(0, 4);
        stop_and_drain();

        // dual panel, burst 64
        do_reset(4);
        put_desc(32'hC0, 32'hC0, 32'h2000, (1 << 30) | (1 << 31) | 100);
        put_desc(32'h100, 32'h100, 32'h3000, (1 << 31) | (30 + ($urandom % 30)));
        start_ch(0, 32'hC0);
        start_ch(1, 32'h100);
        rate[0] = 70;
        rate[1] = 50;
        dual = 1'b1;
        run = 1'b1;
        wait_desc(0, 3);
        wait_desc(1, 3);
        chk(nreq[1] > 0, "R11 lower channel runs with dual", 64'(nreq[1]), 1);
        stop_and_drain();

        // undefined burst code and a zero-length descriptor in the chain
        do_reset(7);
        put_desc(32'h140, 32'h180, 32'h3800, (1 << 30) | (1 << 31) | (1 << 28));
        put_desc(32'h180, 32'h140, 32'h3A00, (1 << 30) | 5);
        start_ch(0, 32'h140);
        run = 1'b1;
        wait_desc(0, 6);
        stop_and_drain();

        // underrun on channel 0 only
        do_reset(2);
        force_rd[0] = 1;
        @(negedge clk); #1;
        force_rd[0] = 0;
        @(negedge clk); #1;
        chk(underrun[0] == 1'b1, "R10 underrun set", underrun[0], 1);
        chk(underrun[1] == 1'b0, "R10 other channel untouched", underrun[1], 0);
        repeat (10) @(negedge clk);
        #1;
        chk(underrun[0] == 1'b1, "R10 underrun sticky", underrun[0], 1);
        do_reset(2);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule